// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block sits in front of a synchronous burst memory array and produces the word address that the array reads or writes on every clock. It accepts a new starting address when an address strobe is seen together with an active chip selection. From that point it walks through a burst of four consecutive beats. The low two address bits are driven by a small beat counter, and the upper bits stay where the capture left them.

There are two address strobes. One comes from the processor side and one from the controller side. When both are low together, the processor strobe takes precedence. The processor strobe is gated by chip enable 1, so it does nothing while that enable is high. An advance input steps the burst one beat at a time. A mode input picks the beat order: an exclusive-or (interleaved) walk or a wrapping increment (linear) walk. The chosen order is latched at capture time.

The block also keeps a registered `selected` flag. The flag tells downstream logic whether the most recent strobe addressed this device.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `memAddr` is all zeros and `selected` is 0.
- R2: When a strobe is sampled low and `chipEn1N`=0, `chipEn2`=1 and `chipEn3N`=0, then from the next cycle `memAddr` equals the sampled `addrIn` and `selected` is 1.
- R3: If both strobes are low in one cycle with all chip enables active, the processor strobe is honoured. This gives one capture of `addrIn`, starting at beat 0.
- R4: A low `procStrobeN` sampled while `chipEn1N`=1 (with `ctrlStrobeN` high) has no effect. `memAddr` and `selected` keep their values.
- R5: A recognised strobe sampled while any chip enable is inactive clears `selected` and leaves `memAddr` unchanged.
- R6: With `interleaveMode`=1 at capture, beat n (n = 0..3) puts (start XOR n) on `memAddr[1:0]`.
- R7: With `interleaveMode`=0 at capture, beat n puts ((start + n) mod 4) on `memAddr[1:0]`.
- R8: With both strobes high and `advanceN` high, `memAddr` and `selected` hold.
- R9: An accepted strobe in the middle of a burst restarts at beat 0 of the new address, even if `advanceN` is low in that cycle.
- R10: Advancing never changes `memAddr[ADDR_W-1:2]`. After the fourth beat, the next advance returns to the starting address.
- R11: The burst order is fixed at capture. Changing `interleaveMode` during a burst does not change the remaining beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| procStrobeN | input | 1 | Processor-side address strobe, active low, gated by `chipEn1N` |
| ctrlStrobeN | input | 1 | Controller-side address strobe, active low |
| chipEn1N | input | 1 | Chip enable 1, active low |
| chipEn2 | input | 1 | Chip enable 2, active high |
| chipEn3N | input | 1 | Chip enable 3, active low |
| advanceN | input | 1 | Burst advance, active low |
| interleaveMode | input | 1 | 1 selects the interleaved order, 0 the linear order (latched at capture) |
| addrIn | input | ADDR_W | Word address to capture |
| memAddr | output | ADDR_W | Current internal memory address |
| selected | output | 1 | Registered device-selected flag |

## Verification
The bench builds the sequencer with its default 17-bit address and 2-bit beat field. At this width an all-ones upper field reaches the top address bit, so a stray carry out of the beat field becomes visible on `memAddr`. Each of the four start offsets is run through both orders, and every beat is compared with a table computed in the bench. The cases that only a full-width address exposes are the wrap after four beats and the restart in mid-burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic deselect;
  } seqStrobes_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        procStrobeN,
  input  logic        ctrlStrobeN,
  input  logic        chipEn1N,
  input  logic        chipEn2,
  input  logic        chipEn3N,
  input  logic        advanceN,
  output seqStrobes_t strobes,
  output logic        selected
);
  logic procHit;
  logic ctrlHit;
  logic anyStrobe;
  logic enablesOn;
  logic selectedReg;

  // processor strobe is only seen while chip enable 1 is low; it wins over ctrl
  assign procHit   = !procStrobeN && !chipEn1N;
  assign ctrlHit   = !ctrlStrobeN && !procHit;
  assign anyStrobe = procHit || ctrlHit;
  assign enablesOn = !chipEn1N && chipEn2 && !chipEn3N;

  always_comb begin
    strobes.load     = anyStrobe && enablesOn;
    strobes.deselect = anyStrobe && !enablesOn;
    strobes.step     = !advanceN && !anyStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 selectedReg <= 1'b0;
    else if (strobes.load)     selectedReg <= 1'b1;
    else if (strobes.deselect) selectedReg <= 1'b0;
  end

  assign selected = selectedReg;

  p_capture_sel_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && !chipEn1N && chipEn2 && !chipEn3N) |=> selectedReg);

  p_ce1_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && chipEn1N && ctrlStrobeN) |=> $stable(selectedReg));

  p_deselect_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && !chipEn2) |=> !selectedReg);

  p_hold_sel_r8: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobeN && ctrlStrobeN) |=> $stable(selectedReg));
endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic              interleaveMode,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] memAddr
);
  localparam int HI_W = ADDR_W - BURST_BITS;

  logic [HI_W-1:0]       upperReg;
  logic [BURST_BITS-1:0] startReg;
  logic [BURST_BITS-1:0] beatReg;
  logic                  modeReg;
  logic [BURST_BITS-1:0] lowBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperReg <= '0;
      startReg <= '0;
      beatReg  <= '0;
      modeReg  <= 1'b0;
    end else if (strobes.load) begin
      upperReg <= addrIn[ADDR_W-1:BURST_BITS];
      startReg <= addrIn[BURST_BITS-1:0];
      beatReg  <= '0;
      modeReg  <= interleaveMode;
    end else if (strobes.step) begin
      beatReg  <= beatReg + 1'b1;
    end
  end

  always_comb begin
    if (modeReg) lowBits = startReg ^ beatReg;
    else         lowBits = startReg + beatReg;
  end

  assign memAddr = {upperReg, lowBits};

  p_step_next_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> beatReg == BURST_BITS'($past(beatReg) + 1'b1));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=>
      ($stable(beatReg) && $stable(upperReg) && $stable(startReg)));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> beatReg == '0);

  p_upper_fixed_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> $stable(upperReg));

  p_mode_locked_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(modeReg));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              chipEn1N,
  input  logic              chipEn2,
  input  logic              chipEn3N,
  input  logic              advanceN,
  input  logic              interleaveMode,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              selected
);
  localparam int BURST_BITS = 2;

  seqStrobes_t strobes;

  burst_seq_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .chipEn1N    (chipEn1N),
    .chipEn2     (chipEn2),
    .chipEn3N    (chipEn3N),
    .advanceN    (advanceN),
    .strobes     (strobes),
    .selected    (selected)
  );

  burst_seq_datapath #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) i_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .interleaveMode (interleaveMode),
    .addrIn         (addrIn),
    .memAddr        (memAddr)
  );
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int ADDR_W = 17;

  logic              clk = 1'b0;
  logic              rstN;
  logic              procStrobeN, ctrlStrobeN, chipEn1N, chipEn2, chipEn3N;
  logic              advanceN, interleaveMode;
  logic [ADDR_W-1:0] addrIn;
  logic [ADDR_W-1:0] memAddr;
  logic              selected;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) i_burst_addr_seq (
    .clk(clk), .rstN(rstN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
    .advanceN(advanceN), .interleaveMode(interleaveMode),
    .addrIn(addrIn), .memAddr(memAddr), .selected(selected)
  );

  task automatic check(string req, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleInputs();
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1;
    chipEn1N = 1'b0; chipEn2 = 1'b1; chipEn3N = 1'b0;
    advanceN = 1'b1;
  endtask

  function automatic logic [ADDR_W-1:0] refAddr(logic [ADDR_W-1:0] base, bit ilv, int n);
    logic [1:0] s = base[1:0];
    logic [1:0] b = 2'(n);
    logic [1:0] lo = ilv ? (s ^ b) : 2'(s + b);
    return {base[ADDR_W-1:2], lo};
  endfunction

  task automatic capture(bit useProc, bit useCtrl, logic [ADDR_W-1:0] a, bit ilv);
    procStrobeN = !useProc; ctrlStrobeN = !useCtrl;
    addrIn = a; interleaveMode = ilv;
    tick();
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1;
    addrIn = '0;
  endtask

  task automatic stepOnce();
    advanceN = 1'b0;
    tick();
    advanceN = 1'b1;
  endtask

  task automatic runBurst(string req, bit useProc, logic [ADDR_W-1:0] a, bit ilv);
    capture(useProc, !useProc, a, ilv);
    check("R2", {{(ADDR_W-1){1'b0}}, selected}, 1);
    check(req, memAddr, refAddr(a, ilv, 0));
    for (int n = 1; n < 4; n++) begin
      stepOnce();
      check(req, memAddr, refAddr(a, ilv, n));
    end
    stepOnce();
    check("R10", memAddr, a);
  endtask

  task automatic testReset();
    check("R1", memAddr, '0);
    check("R1", {{(ADDR_W-1){1'b0}}, selected}, 0);
  endtask

  task automatic testInterleaved();
    for (int s = 0; s < 4; s++)
      runBurst("R6", 1'b1, ADDR_W'(17'h1_FFFC | s), 1'b1);
  endtask

  task automatic testLinear();
    for (int s = 0; s < 4; s++)
      runBurst("R7", 1'b0, ADDR_W'(17'h0_A5A4 | s), 1'b0);
  endtask

  task automatic testBothStrobes();
    capture(1'b1, 1'b1, 17'h0_3332, 1'b0);
    check("R3", memAddr, 17'h0_3332);
    stepOnce();
    check("R3", memAddr, 17'h0_3333);
  endtask

  task automatic testCe1Gate();
    capture(1'b0, 1'b1, 17'h1_2340, 1'b1);
    chipEn1N = 1'b1;
    capture(1'b1, 1'b0, 17'h0_0F0F, 1'b1);
    chipEn1N = 1'b0;
    check("R4", memAddr, 17'h1_2340);
    check("R4", {{(ADDR_W-1){1'b0}}, selected}, 1);
  endtask

  task automatic testDeselect();
    capture(1'b0, 1'b1, 17'h0_7771, 1'b0);
    chipEn2 = 1'b0;
    capture(1'b0, 1'b1, 17'h1_0000, 1'b0);
    chipEn2 = 1'b1;
    check("R5", memAddr, 17'h0_7771);
    check("R5", {{(ADDR_W-1){1'b0}}, selected}, 0);
    chipEn3N = 1'b1;
    capture(1'b1, 1'b0, 17'h1_1111, 1'b0);
    chipEn3N = 1'b0;
    check("R5", memAddr, 17'h0_7771);
  endtask

  task automatic testHold();
    capture(1'b1, 1'b0, 17'h0_5556, 1'b1);
    stepOnce();
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R8", memAddr, 17'h0_5557);
      check("R8", {{(ADDR_W-1){1'b0}}, selected}, 1);
    end
  endtask

  task automatic testRestart();
    capture(1'b0, 1'b1, 17'h0_1235, 1'b0);
    stepOnce();
    stepOnce();
    advanceN = 1'b0;
    capture(1'b0, 1'b1, 17'h1_8882, 1'b1);
    advanceN = 1'b1;
    check("R9", memAddr, 17'h1_8882);
    stepOnce();
    check("R9", memAddr, 17'h1_8883);
  endtask

  task automatic testModeLock();
    capture(1'b1, 1'b0, 17'h0_4441, 1'b1);
    interleaveMode = 1'b0;
    stepOnce();
    check("R11", memAddr, 17'h0_4440);
    stepOnce();
    check("R11", memAddr, 17'h0_4443);
  endtask

  initial begin
    idleInputs();
    interleaveMode = 1'b0;
    addrIn = '0;
    rstN = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testInterleaved();
    testLinear();
    testBothStrobes();
    testCe1Gate();
    testDeselect();
    testHold();
    testRestart();
    testModeLock();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule